// File: doc/BRIEF.md
# Twiddle Exponent Sequencer

This block produces, one per handshake, the twiddle-factor exponents that a single butterfly stage of a mixed-radix FFT consumes. A controller loads a stage description and pulses `start`. The block then walks three nested loops: an outer index k, a middle index l and an innermost butterfly-leg index. For each position it emits the exponent reduced modulo the transform size N. That reduced value addresses a twiddle ROM that sits outside this block. The same three-value description (outer count, middle count, weight) serves a plain 1-D stage and a stage of a multidimensional transform mapped onto one 1-D index space. Only the values loaded differ between the two.

A second mode serves a radix-16 stage that the datapath splits into two radix-4 passes. In this mode every (k, l) group produces 16 exponents. For each quarter n from 0 to 3 it emits n·k·w, then m·(n·G + k)·(w/4) for m = 1, 2, 3. The products are never formed. Every exponent comes from running modular additions, so the datapath holds only adders and comparators.

Top module: `twf_exp_gen`

## Requirements
- R1: With `cfg_mode` = 0 the block emits F·L·r exponents in the order k outer, l middle, leg m innermost (m from 0 to r−1). Each value is (m·k·w) mod N, where F = `cfg_outer`, L = `cfg_inner`, r = `cfg_radix` and w = `cfg_weight`.
- R2: With `cfg_mode` = 1 each (k, l) group emits 16 exponents, k outer and l middle. For n = 0..3 in turn, the group emits (n·k·w) mod N followed by (m·(n·G + k)·⌊w/4⌋) mod N for m = 1, 2, 3. `cfg_stride` carries the pre-scaled offset (G·⌊w/4⌋) mod N.
- R3: Every emitted exponent is smaller than N = `cfg_size`.
- R4: The first exponent of every group is 0. A group is one leg run in mode 0, and the n = 0 slot of a 16-exponent group in mode 1.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_exp` keeps its value on the next cycle.
- R6: `out_last` is high exactly with the final exponent of the stage. `done` is high for the single cycle after that exponent is accepted, and `busy` and `out_valid` are low from that cycle on.
- R7: The configuration is captured on the `start` cycle. A `start` pulse or a configuration change while `busy` is high has no effect on the sequence being produced.
- R8: After reset `busy`, `out_valid` and `done` are low. The first exponent is offered in the cycle after an accepted `start`.
- R9: Inputs must satisfy F ≥ 1, L ≥ 1, r ≥ 2, w < N and `cfg_stride` < N. Within these limits no emitted exponent differs from the exact product reduced mod N, for any number of wraps past N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a stage when idle |
| cfg_mode | input | 1 | 0: plain stage, 1: split radix-16 stage |
| cfg_size | input | AW+1 | Transform size N, the modulus |
| cfg_outer | input | CW | Outer count F |
| cfg_inner | input | CW | Middle count L |
| cfg_radix | input | RW | Leg count r for mode 0 |
| cfg_weight | input | AW | Stage weight w |
| cfg_stride | input | AW | Mode 1 quarter offset (G·⌊w/4⌋) mod N |
| out_valid | output | 1 | Exponent available |
| out_ready | input | 1 | Consumer accepts the exponent |
| out_exp | output | AW | Exponent mod N |
| out_last | output | 1 | Final exponent of the stage |
| done | output | 1 | One-cycle pulse after the final accept |
| busy | output | 1 | Stage in progress |

## Verification
The hardest case is one accept that ends a group and also wraps the middle count, so the outer index advances in the same cycle. On that edge the running k·w and k·⌊w/4⌋ accumulators step forward. In mode 1, the next group's first quarter offset must be loaded from the already advanced k·⌊w/4⌋ sum, not the old one. Stages with a middle count of 1 and small N force this coincidence on every group, under an irregular ready pattern. Each exponent after the boundary is compared against a product computed directly in the bench.

// File: rtl/twf_pkg.sv
package twf_pkg;

    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_QR16  = 1'b1
    } twf_mode_e;

    // Phases and quarters of a split radix-16 group.
    localparam int unsigned QR16_SLOTS = 4;

endpackage

// File: rtl/twf_modadd.sv
module twf_modadd #(
    parameter int unsigned AW = 12
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic [AW:0]   modulus,
    output logic [AW-1:0] sum_mod
);
    logic [AW:0] raw;
    logic [AW:0] reduced;

    always_comb begin
        raw     = {1'b0, a} + {1'b0, b};
        reduced = (raw >= modulus) ? (raw - modulus) : raw;
        sum_mod = reduced[AW-1:0];
    end
endmodule

// File: rtl/twf_cnt.sv
module twf_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] lim,
    output logic [W-1:0] val,
    output logic         at_lim
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (clr) begin
            val_d = '0;
        end else if (inc) begin
            val_d = (val_q == lim) ? '0 : val_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val    = val_q;
    assign at_lim = (val_q == lim);
endmodule

// File: rtl/twf_exp_gen.sv
module twf_exp_gen
    import twf_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned CW = 10,
    parameter int unsigned RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_mode,
    input  logic [AW:0]   cfg_size,
    input  logic [CW-1:0] cfg_outer,
    input  logic [CW-1:0] cfg_inner,
    input  logic [RW-1:0] cfg_radix,
    input  logic [AW-1:0] cfg_weight,
    input  logic [AW-1:0] cfg_stride,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_exp,
    output logic          out_last,
    output logic          done,
    output logic          busy
);
    localparam int unsigned PW = (RW > 2) ? RW : 2;
    localparam logic [PW-1:0] QR16_PLIM = PW'(QR16_SLOTS - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        twf_mode_e     mode;
        logic [AW:0]   size;
        logic [CW-1:0] k_lim;
        logic [CW-1:0] l_lim;
        logic [PW-1:0] p_lim;
        logic [AW-1:0] w;
        logic [AW-1:0] s;
        logic [AW-1:0] acc;   // running leg exponent
        logic [AW-1:0] step;  // k*w mod N
        logic [AW-1:0] kq;    // k*(w/4) mod N
        logic [AW-1:0] na;    // n*k*w mod N
        logic [AW-1:0] cb;    // (n*G+k)*(w/4) mod N
    } st_t;

    st_t st_d, st_q;

    logic          quasi;
    logic          fire;
    logic          go;
    logic [PW-1:0] p_val;
    logic [1:0]    n_val;
    logic [CW-1:0] l_val, k_val;
    logic          p_at, n_at, l_at, k_at;
    logic          grp_end, stage_end;
    logic [1:0]    n_lim;
    logic [AW-1:0] acc_inc, acc_plus, step_plus, kq_plus, na_plus, cb_plus;
    logic [AW-1:0] quarter_w;

    assign quasi     = (st_q.mode == MODE_QR16);
    assign fire      = st_q.busy & out_ready;
    assign go        = start & ~st_q.busy;
    assign n_lim     = quasi ? 2'(QR16_SLOTS - 1) : 2'd0;
    assign quarter_w = st_q.w >> 2;
    assign acc_inc   = quasi ? st_q.cb : st_q.step;

    // Loop counters: leg/phase p, quarter n, middle l, outer k.
    twf_cnt #(.W(PW)) u_cnt_p (
        .clk(clk), .rst_n(rst_n), .clr(go), .inc(fire),
        .lim(st_q.p_lim), .val(p_val), .at_lim(p_at)
    );
    twf_cnt #(.W(2)) u_cnt_n (
        .clk(clk), .rst_n(rst_n), .clr(go), .inc(fire & p_at),
        .lim(n_lim), .val(n_val), .at_lim(n_at)
    );
    twf_cnt #(.W(CW)) u_cnt_l (
        .clk(clk), .rst_n(rst_n), .clr(go), .inc(fire & p_at & n_at),
        .lim(st_q.l_lim), .val(l_val), .at_lim(l_at)
    );
    twf_cnt #(.W(CW)) u_cnt_k (
        .clk(clk), .rst_n(rst_n), .clr(go), .inc(fire & p_at & n_at & l_at),
        .lim(st_q.k_lim), .val(k_val), .at_lim(k_at)
    );

    assign grp_end   = p_at & n_at;
    assign stage_end = grp_end & l_at & k_at;

    // Modular adders replace every multiplication.
    twf_modadd #(.AW(AW)) u_add_acc (
        .a(st_q.acc), .b(acc_inc), .modulus(st_q.size), .sum_mod(acc_plus));
    twf_modadd #(.AW(AW)) u_add_step (
        .a(st_q.step), .b(st_q.w), .modulus(st_q.size), .sum_mod(step_plus));
    twf_modadd #(.AW(AW)) u_add_kq (
        .a(st_q.kq), .b(quarter_w), .modulus(st_q.size), .sum_mod(kq_plus));
    twf_modadd #(.AW(AW)) u_add_na (
        .a(st_q.na), .b(st_q.step), .modulus(st_q.size), .sum_mod(na_plus));
    twf_modadd #(.AW(AW)) u_add_cb (
        .a(st_q.cb), .b(st_q.s), .modulus(st_q.size), .sum_mod(cb_plus));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (go) begin
            st_d.busy  = 1'b1;
            st_d.mode  = twf_mode_e'(cfg_mode);
            st_d.size  = cfg_size;
            st_d.k_lim = cfg_outer - 1'b1;
            st_d.l_lim = cfg_inner - 1'b1;
            st_d.p_lim = cfg_mode ? QR16_PLIM : PW'(cfg_radix - 1'b1);
            st_d.w     = cfg_weight;
            st_d.s     = cfg_stride;
            st_d.acc   = '0;
            st_d.step  = '0;
            st_d.kq    = '0;
            st_d.na    = '0;
            st_d.cb    = '0;
        end else if (fire) begin
            if (quasi) begin
                if (p_val == '0)  st_d.acc = st_q.cb;
                else if (p_at)    st_d.acc = '0;
                else              st_d.acc = acc_plus;
                if (p_at) begin
                    st_d.na = na_plus;
                    st_d.cb = cb_plus;
                end
            end else begin
                st_d.acc = p_at ? '0 : acc_plus;
            end
            if (grp_end) begin
                st_d.acc = '0;
                st_d.na  = '0;
                if (l_at) begin
                    st_d.step = step_plus;
                    st_d.kq   = kq_plus;
                    st_d.cb   = kq_plus;
                end else begin
                    st_d.cb   = st_q.kq;
                end
            end
            if (stage_end) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign out_valid = st_q.busy;
    assign out_exp   = (quasi && p_val == '0) ? st_q.na : st_q.acc;
    assign out_last  = st_q.busy & stage_end;

    // Assertions
    assert_exp_below_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_exp} < st_q.size));

    assert_group_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && p_val == '0 && (!quasi || n_val == 2'd0)) |-> (out_exp == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_exp)));

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready && out_last));

    assert_cfg_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(st_q.size) && $stable(st_q.w) && $stable(st_q.mode)));

    assert_counters_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (k_val <= st_q.k_lim && l_val <= st_q.l_lim && p_val <= st_q.p_lim));
endmodule

// File: tb/twf_exp_gen_bench.sv
module twf_exp_gen_bench;
    localparam int AW = 12;
    localparam int CW = 10;
    localparam int RW = 5;
    localparam int ROWS = 7;
    localparam int WATCHDOG = 150000;

    // columns: mode, N, F, L, r, w, G
    localparam int TAB [0:ROWS-1][0:6] = '{
        '{0,  36,  3, 4, 3, 12,  0},
        '{0,  36,  6, 2, 2,  6,  0},
        '{0,  36,  2, 6, 3,  6,  0},
        '{0,  64, 16, 1, 4,  4,  0},
        '{1, 256,  4, 2, 4, 16, 16},
        '{1,  64,  2, 1, 4,  4,  4},
        '{0,   8,  1, 1, 2,  1,  0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cfg_mode = 1'b0;
    logic [AW:0]   cfg_size = '0;
    logic [CW-1:0] cfg_outer = '0;
    logic [CW-1:0] cfg_inner = '0;
    logic [RW-1:0] cfg_radix = '0;
    logic [AW-1:0] cfg_weight = '0;
    logic [AW-1:0] cfg_stride = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [AW-1:0] out_exp;
    logic          out_last;
    logic          done;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    twf_exp_gen #(.AW(AW), .CW(CW), .RW(RW)) u_twf_exp_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_size(cfg_size), .cfg_outer(cfg_outer), .cfg_inner(cfg_inner),
        .cfg_radix(cfg_radix), .cfg_weight(cfg_weight), .cfg_stride(cfg_stride),
        .out_valid(out_valid), .out_ready(out_ready), .out_exp(out_exp),
        .out_last(out_last), .done(done), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_exp(input int row, input int idx);
        int md = TAB[row][0];
        int nn = TAB[row][1];
        int ll = TAB[row][3];
        int rr = TAB[row][4];
        int ww = TAB[row][5];
        int gg = TAB[row][6];
        if (md == 0) begin
            int m = idx % rr;
            int k = (idx / rr) / ll;
            return (m * k * ww) % nn;
        end else begin
            int j = idx % 16;
            int k = (idx / 16) / ll;
            int n = j / 4;
            int p = j % 4;
            if (p == 0) return (n * k * ww) % nn;
            return (p * (n * gg + k) * (ww / 4)) % nn;
        end
    endfunction

    function automatic int row_total(input int row);
        int per = (TAB[row][0] == 0) ? TAB[row][4] : 16;
        return TAB[row][2] * TAB[row][3] * per;
    endfunction

    task automatic load_cfg(input int row);
        cfg_mode   = TAB[row][0][0];
        cfg_size   = (AW+1)'(TAB[row][1]);
        cfg_outer  = CW'(TAB[row][2]);
        cfg_inner  = CW'(TAB[row][3]);
        cfg_radix  = RW'(TAB[row][4]);
        cfg_weight = AW'(TAB[row][5]);
        cfg_stride = AW'((TAB[row][6] * (TAB[row][5] / 4)) % TAB[row][1]);
    endtask

    // poke: disturb start/config mid-run; stall: hold ready low and watch output
    task automatic run_row(input int row, input bit poke, input bit stall);
        int total = row_total(row);
        int idx = 0;
        int guard = 0;
        string rq = (TAB[row][0] == 0) ? "R1" : "R2";
        @(negedge clk);
        load_cfg(row);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 first offer", int'(out_valid), 1);
        while (idx < total && guard < 20000) begin
            guard++;
            if (stall && idx == 2) begin
                int held;
                out_ready = 1'b0;
                #1;
                held = int'(out_exp);
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    check("R5 valid held", int'(out_valid), 1);
                    check("R5 exp held", int'(out_exp), held);
                end
            end
            if (poke && idx == 1) begin
                start = 1'b1;
                cfg_mode = 1'b1;
                cfg_size = (AW+1)'(8);
                cfg_weight = AW'(5);
                cfg_outer = CW'(1);
            end else begin
                start = 1'b0;
            end
            out_ready = ((cyc * 7 + row) % 5) != 0;
            #1;
            if (out_valid && out_ready) begin
                check(rq, int'(out_exp), ref_exp(row, idx));
                check("R6 last flag", int'(out_last), int'(idx == total - 1));
                check("R3 range", int'(out_exp < AW'(TAB[row][1])), 1);
                idx++;
            end
            @(negedge clk);
        end
        start = 1'b0;
        out_ready = 1'b0;
        check("R9 count", idx, total);
        check("R6 done pulse", int'(done), 1);
        check("R6 busy low", int'(busy), 0);
        check("R6 valid low", int'(out_valid), 0);
        @(negedge clk);
        check("R6 done single", int'(done), 0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset busy", int'(busy), 0);
        check("R8 reset valid", int'(out_valid), 0);
        check("R8 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle after reset", int'(out_valid), 0);

        for (int r = 0; r < ROWS; r++) begin
            run_row(r, 1'b0, 1'b0);
        end

        // R7: start and config disturbed mid-run
        run_row(0, 1'b1, 1'b0);
        run_row(5, 1'b1, 1'b0);
        // R5: back-pressure in both modes
        run_row(4, 1'b0, 1'b1);
        run_row(2, 1'b0, 1'b1);
        // R4 / R9: group wrap with outer advance every group
        run_row(3, 1'b0, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule